// File: doc/BRIEF.md
# Dual write-combining buffer

This block sits between a CPU port that writes one byte at a time and a slow memory port that takes a 64-bit word with per-byte enables. Incoming bytes are gathered into one of two buffers. Each buffer holds an 8-byte naturally aligned region and remembers which of its bytes have been written. A run of writes to the same region becomes a single merged memory write. Only the bytes that were written have their enables set, so the other bytes in memory keep their old values.

A write is acknowledged two cycles after it is presented, as long as a buffer can take it. The requester stalls only when both buffers are occupied and neither one can absorb the byte. The flush policy depends on load. While the second buffer is still free, a partly filled buffer is kept open so that following sequential writes can chain into it. It is flushed once it is full, or once it has seen no write for a set number of cycles. When both buffers are occupied, the older one is sent to memory at once.

Buffers drain in the order they were allocated. A snoop port looks up any byte still held in a buffer, so a read path can stay coherent with writes that are still pending.

Top module: `wrcomb_top`

## Requirements
- R1: After reset, `wr_ack`, `mem_req` and `snoop_hit` are low, and no memory write is issued until a byte has been written.
- R2: A write presented while a buffer can take it is acknowledged by a one-cycle `wr_ack` pulse. The pulse is sampled high in the second cycle after the request is first sampled. The requester holds `wr_req`, `wr_addr` and `wr_data` until it sees the pulse.
- R3: Bytes written to the same 8-byte aligned region while it is buffered leave in one memory write. The last byte written to a position wins. No accepted byte is lost.
- R4: A memory write carries the region index `addr >> 3` on `mem_addr`. The byte at region offset i sits on `mem_data[8*i+7:8*i]`, and `mem_be` bit i is set exactly when offset i was written.
- R5: While the other buffer is empty, a partly filled buffer is flushed only after IDLE_LIMIT cycles without a write to it. Counting from the cycle in which `wr_ack` is seen high, `mem_req` stays low for IDLE_LIMIT cycles and is high in the following one.
- R6: A buffer whose eight bytes have all been written is flushed at once: `mem_req` is high in the cycle after the final `wr_ack`.
- R7: When both buffers are occupied, the older one is flushed at once. A write that hits neither open buffer is not acknowledged until a buffer has been freed.
- R8: A write to a region whose buffer is already being flushed never changes the data in flight. It opens the other buffer without stalling when that buffer is free.
- R9: Buffers reach memory in allocation order, so two writes to the same byte arrive in program order.
- R10: One cycle after `snoop_addr` is applied, `snoop_hit` reports whether that byte is held in a buffer, including one being flushed. `snoop_data` returns the byte from the newer buffer when both hold it.
- R11: `mem_req`, `mem_addr`, `mem_data` and `mem_be` stay unchanged from the cycle `mem_req` rises until `mem_ack` is sampled high. `mem_req` is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Byte write request, held until acknowledged |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 8 | Byte to write |
| wr_ack | output | 1 | One-cycle acknowledge of the held write |
| snoop_addr | input | AW | Byte address to look up in the buffers |
| snoop_hit | output | 1 | Looked-up byte is pending in a buffer |
| snoop_data | output | 8 | Pending value of the looked-up byte |
| mem_req | output | 1 | Memory write request, held until `mem_ack` |
| mem_addr | output | AW-3 | Aligned region index of the memory write |
| mem_data | output | 64 | Merged write data, byte i at bits 8i+7..8i |
| mem_be | output | 8 | Byte enables of the memory write |
| mem_ack | input | 1 | Memory accepts the current write |

## Verification
The bench builds the block with AW = 12, which gives a 4 KiB shadow of the address space. That lets the memory the block produced be compared with the one the CPU wrote, byte for byte. IDLE_LIMIT is set to 6, which keeps the exact idle-flush cycle short enough to pin down while still being longer than the gap between back-to-back writes, so chaining is exercised. The memory model's acknowledge latency is varied up to 15 cycles. This holds a flush in flight long enough to force stalls, to land writes on a region that is being drained, and to snoop data that is still in flight.

// File: rtl/wrcomb_pkg.sv
package wrcomb_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_FILL  = 2'd1,
    SLOT_DRAIN = 2'd2
  } slot_st_e;

endpackage

// File: rtl/wrcomb_slot.sv
module wrcomb_slot #(
  parameter int LANE_BITS  = 3,
  parameter int TAG_W      = 13,
  parameter int IDLE_LIMIT = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       alloc,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic [LANE_BITS-1:0]       wr_lane,
  input  logic [7:0]                 wr_byte,
  input  logic                       launch,
  input  logic                       free_i,
  input  logic [TAG_W-1:0]           snoop_tag,
  input  logic [LANE_BITS-1:0]       snoop_lane,
  output wrcomb_pkg::slot_st_e       st_o,
  output logic [TAG_W-1:0]           tag_o,
  output logic [(8<<LANE_BITS)-1:0]  data_o,
  output logic [(1<<LANE_BITS)-1:0]  mask_o,
  output logic                       idle_done,
  output logic                       snoop_match,
  output logic [7:0]                 snoop_byte
);
  import wrcomb_pkg::*;

  localparam int LANES = 1 << LANE_BITS;
  localparam int IW    = $clog2(IDLE_LIMIT + 1);

  slot_st_e          st_q;
  logic [TAG_W-1:0]  tag_q;
  logic [LANES-1:0]  mask_q;
  logic [IW-1:0]     idle_q;
  logic [8*LANES-1:0] data_q;
  logic [LANES-1:0]  lane_bit;

  assign lane_bit = LANES'(1) << wr_lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SLOT_EMPTY;
      tag_q  <= '0;
      mask_q <= '0;
      idle_q <= '0;
    end else begin
      if (free_i) begin
        st_q   <= SLOT_EMPTY;
        mask_q <= '0;
      end else if (launch) begin
        st_q <= SLOT_DRAIN;
      end
      if (wr_en) begin
        idle_q <= '0;
        if (alloc) begin
          st_q   <= SLOT_FILL;
          tag_q  <= wr_tag;
          mask_q <= lane_bit;
        end else begin
          mask_q <= mask_q | lane_bit;
        end
      end else if (st_q == SLOT_FILL && idle_q < IW'(IDLE_LIMIT)) begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  // byte-lane storage, no reset so it maps onto plain RAM bits
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_lane == LANE_BITS'(g))
        data_q[g*8 +: 8] <= wr_byte;
    end
  end

  assign st_o        = st_q;
  assign tag_o       = tag_q;
  assign data_o      = data_q;
  assign mask_o      = mask_q;
  assign idle_done   = (idle_q >= IW'(IDLE_LIMIT));
  assign snoop_match = (st_q != SLOT_EMPTY) && (tag_q == snoop_tag) && mask_q[snoop_lane];
  assign snoop_byte  = data_q[snoop_lane*8 +: 8];

  // data in flight must never be touched (R8)
  p_frozen_in_flight_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == SLOT_DRAIN) |-> !wr_en);

  // a flush only starts from an open buffer (R5)
  p_launch_from_fill_r5: assert property (@(posedge clk) disable iff (rst)
    launch |-> (st_q == SLOT_FILL));

  // a buffer is only released after its write was in flight (R11)
  p_free_from_drain_r11: assert property (@(posedge clk) disable iff (rst)
    free_i |-> (st_q == SLOT_DRAIN));

endmodule

// File: rtl/wrcomb_drain.sv
module wrcomb_drain #(
  parameter int TAG_W = 13,
  parameter int LANES = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  wrcomb_pkg::slot_st_e [1:0]    st_i,
  input  logic [1:0]                    full_i,
  input  logic [1:0]                    idle_i,
  input  logic [1:0][TAG_W-1:0]         tag_i,
  input  logic [1:0][8*LANES-1:0]       data_i,
  input  logic [1:0][LANES-1:0]         mask_i,
  input  logic                          alloc_i,
  input  logic                          mem_ack,
  output logic                          head_o,
  output logic [1:0]                    count_o,
  output logic [1:0]                    launch_o,
  output logic [1:0]                    free_o,
  output logic                          mem_req,
  output logic [TAG_W-1:0]              mem_addr,
  output logic [8*LANES-1:0]            mem_data,
  output logic [LANES-1:0]              mem_be
);
  import wrcomb_pkg::*;

  logic       head_q;
  logic [1:0] count_q;
  logic       go;
  logic       done;

  // only the oldest buffer may start, and only one write is in flight
  assign go   = !mem_req && (st_i[head_q] == SLOT_FILL) &&
                (full_i[head_q] || count_q == 2'd2 || idle_i[head_q]);
  assign done = mem_req && mem_ack;

  assign launch_o = go   ? (2'b01 << head_q) : 2'b00;
  assign free_o   = done ? (2'b01 << head_q) : 2'b00;
  assign head_o   = head_q;
  assign count_o  = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q   <= 1'b0;
      count_q  <= 2'd0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      mem_be   <= '0;
    end else begin
      count_q <= count_q + {1'b0, alloc_i} - {1'b0, done};
      if (done) begin
        mem_req <= 1'b0;
        head_q  <= ~head_q;
      end else if (go) begin
        mem_req  <= 1'b1;
        mem_addr <= tag_i[head_q];
        mem_data <= data_i[head_q];
        mem_be   <= mask_i[head_q];
      end
    end
  end

  p_count_max_r7: assert property (@(posedge clk) disable iff (rst)
    count_q <= 2'd2);

  p_both_busy_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (count_q == 2'd2 && !mem_req) |=> mem_req);

  p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_data) && $stable(mem_be)));

  p_enables_present_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_be != '0));

endmodule

// File: rtl/wrcomb_top.sv
module wrcomb_top #(
  parameter int AW         = 16,
  parameter int LANE_BITS  = 3,
  parameter int IDLE_LIMIT = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_req,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [7:0]                    wr_data,
  output logic                          wr_ack,
  input  logic [AW-1:0]                 snoop_addr,
  output logic                          snoop_hit,
  output logic [7:0]                    snoop_data,
  output logic                          mem_req,
  output logic [AW-LANE_BITS-1:0]       mem_addr,
  output logic [(8<<LANE_BITS)-1:0]     mem_data,
  output logic [(1<<LANE_BITS)-1:0]     mem_be,
  input  logic                          mem_ack
);
  import wrcomb_pkg::*;

  localparam int LANES = 1 << LANE_BITS;
  localparam int DW    = 8 * LANES;
  localparam int TAG_W = AW - LANE_BITS;

  // request stage
  logic                 s1_valid;
  logic [TAG_W-1:0]     s1_tag;
  logic [LANE_BITS-1:0] s1_lane;
  logic [7:0]           s1_byte;

  // slot state
  slot_st_e [1:0]             st;
  logic [1:0][TAG_W-1:0]      tag;
  logic [1:0][DW-1:0]         data;
  logic [1:0][LANES-1:0]      mask;
  logic [1:0]                 idle_done;
  logic [1:0]                 full;
  logic [1:0]                 launch;
  logic [1:0]                 free_s;
  logic [1:0]                 wr_en;
  logic [1:0]                 snp_match;
  logic [1:0][7:0]            snp_byte;
  logic                       head;
  logic [1:0]                 count;

  // placement decision
  logic [1:0] hit;
  logic       alloc_idx;
  logic       can_alloc;
  logic       take;
  logic       is_alloc;

  logic [TAG_W-1:0]     sn_tag;
  logic [LANE_BITS-1:0] sn_lane;

  assign sn_tag  = snoop_addr[AW-1:LANE_BITS];
  assign sn_lane = snoop_addr[LANE_BITS-1:0];

  always_comb begin
    for (int i = 0; i < 2; i++)
      hit[i] = s1_valid && (st[i] == SLOT_FILL) && (tag[i] == s1_tag) && !launch[i];
    alloc_idx = (count == 2'd0) ? head : ~head;
    can_alloc = (count != 2'd2) && (st[alloc_idx] == SLOT_EMPTY);
    take      = s1_valid && ((|hit) || can_alloc);
    is_alloc  = !(|hit);
    for (int i = 0; i < 2; i++)
      wr_en[i] = take && ((|hit) ? hit[i] : (alloc_idx == 1'(i)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_tag   <= '0;
      s1_lane  <= '0;
      s1_byte  <= '0;
      wr_ack   <= 1'b0;
    end else begin
      wr_ack <= take;
      if (take) begin
        s1_valid <= 1'b0;
      end else if (wr_req && !s1_valid) begin
        s1_valid <= 1'b1;
        s1_tag   <= wr_addr[AW-1:LANE_BITS];
        s1_lane  <= wr_addr[LANE_BITS-1:0];
        s1_byte  <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_slot
    wrcomb_slot #(
      .LANE_BITS (LANE_BITS),
      .TAG_W     (TAG_W),
      .IDLE_LIMIT(IDLE_LIMIT)
    ) u_slot (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en[g]),
      .alloc      (is_alloc),
      .wr_tag     (s1_tag),
      .wr_lane    (s1_lane),
      .wr_byte    (s1_byte),
      .launch     (launch[g]),
      .free_i     (free_s[g]),
      .snoop_tag  (sn_tag),
      .snoop_lane (sn_lane),
      .st_o       (st[g]),
      .tag_o      (tag[g]),
      .data_o     (data[g]),
      .mask_o     (mask[g]),
      .idle_done  (idle_done[g]),
      .snoop_match(snp_match[g]),
      .snoop_byte (snp_byte[g])
    );
    assign full[g] = &mask[g];
  end

  wrcomb_drain #(
    .TAG_W(TAG_W),
    .LANES(LANES)
  ) u_drain (
    .clk     (clk),
    .rst     (rst),
    .st_i    (st),
    .full_i  (full),
    .idle_i  (idle_done),
    .tag_i   (tag),
    .data_i  (data),
    .mask_i  (mask),
    .alloc_i (take && is_alloc),
    .mem_ack (mem_ack),
    .head_o  (head),
    .count_o (count),
    .launch_o(launch),
    .free_o  (free_s),
    .mem_req (mem_req),
    .mem_addr(mem_addr),
    .mem_data(mem_data),
    .mem_be  (mem_be)
  );

  // snoop: the newer buffer wins when both hold the byte
  always_ff @(posedge clk) begin
    if (rst) begin
      snoop_hit  <= 1'b0;
      snoop_data <= '0;
    end else begin
      snoop_hit <= |snp_match;
      if (snp_match[~head])
        snoop_data <= snp_byte[~head];
      else
        snoop_data <= snp_byte[head];
    end
  end

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> !wr_ack);

  // one region never lives in two open buffers (R3)
  p_single_open_region_r3: assert property (@(posedge clk) disable iff (rst)
    !(st[0] == SLOT_FILL && st[1] == SLOT_FILL && tag[0] == tag[1]));

endmodule

// File: tb/wrcomb_top_tb_top.sv
module wrcomb_top_tb_top;
  localparam int AW  = 12;
  localparam int LIM = 6;
  localparam int TW  = AW - 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          wr_ack;
  logic [AW-1:0] snoop_addr = '0;
  logic          snoop_hit;
  logic [7:0]    snoop_data;
  logic          mem_req;
  logic [TW-1:0] mem_addr;
  logic [63:0]   mem_data;
  logic [7:0]    mem_be;
  logic          mem_ack = 1'b0;

  always #5 clk = ~clk;

  wrcomb_top #(.AW(AW), .LANE_BITS(3), .IDLE_LIMIT(LIM)) dut_i (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .snoop_addr(snoop_addr), .snoop_hit(snoop_hit),
    .snoop_data(snoop_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be), .mem_ack(mem_ack)
  );

  typedef struct {
    logic [TW-1:0] tag;
    logic [63:0]   data;
    logic [7:0]    be;
  } item_t;

  item_t      expq[$];
  int         checks = 0;
  int         fails = 0;
  int         mem_lat = 2;
  int         lat_cnt = 0;
  logic [7:0] model [1<<AW];
  logic [7:0] shadow[1<<AW];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [TW-1:0] t, input logic [63:0] d, input logic [7:0] b);
    item_t it;
    it.tag = t; it.data = d; it.be = b;
    expq.push_back(it);
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt >= mem_lat) begin
        item_t e;
        logic [63:0] m;
        mem_ack <= 1'b1;
        lat_cnt <= 0;
        for (int i = 0; i < 8; i++) begin
          m[i*8 +: 8] = {8{mem_be[i]}};
          if (mem_be[i]) model[{mem_addr, 3'(i)}] = mem_data[i*8 +: 8];
        end
        if (expq.size() == 0) begin
          check(1'b0, "R9", "unexpected memory write", {55'd0, mem_addr}, 64'd0);
        end else begin
          e = expq.pop_front();
          check(mem_addr == e.tag, "R9", "write order / region", {55'd0, mem_addr}, {55'd0, e.tag});
          check(mem_be == e.be, "R4", "byte enables", {56'd0, mem_be}, {56'd0, e.be});
          check((mem_data & m) == (e.data & m), "R3", "merged data", mem_data & m, e.data & m);
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, output int cyc);
    wr_req = 1'b1; wr_addr = a; wr_data = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!wr_ack && cyc < 500);
    wr_req = 1'b0;
    shadow[a] = d;
  endtask

  task automatic do_snoop(input logic [AW-1:0] a, output logic h, output logic [7:0] d);
    snoop_addr = a;
    @(negedge clk);
    h = snoop_hit; d = snoop_data;
  endtask

  task automatic wait_drain();
    int guard = 0;
    while ((expq.size() != 0 || mem_req) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stimulus
    int cyc;
    logic h;
    logic [7:0] sd;
    logic [63:0] dv;
    bit quiet;
    for (int i = 0; i < (1<<AW); i++) begin model[i] = 8'h00; shadow[i] = 8'h00; end

    repeat (3) @(negedge clk);
    // R1: reset state
    check(!wr_ack, "R1", "wr_ack in reset", {63'd0, wr_ack}, 64'd0);
    check(!mem_req, "R1", "mem_req in reset", {63'd0, mem_req}, 64'd0);
    check(!snoop_hit, "R1", "snoop_hit in reset", {63'd0, snoop_hit}, 64'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(!mem_req, "R1", "no spurious write", {63'd0, mem_req}, 64'd0);

    // single byte: R2 latency, R5 idle flush, R4 layout
    push_exp(TW'(12'h100 >> 3), 64'h00000000000000A5, 8'h01);
    do_write(12'h100, 8'hA5, cyc);
    check(cyc == 2, "R2", "ack latency", 64'(cyc), 64'd2);
    quiet = 1'b1;
    for (int i = 0; i < LIM; i++) begin
      @(negedge clk);
      if (mem_req) quiet = 1'b0;
    end
    check(quiet, "R5", "partial buffer held while idle", {63'd0, !quiet}, 64'd0);
    @(negedge clk);
    check(mem_req, "R5", "idle flush cycle", {63'd0, mem_req}, 64'd1);
    wait_drain();

    // merge with overwrite, full buffer flushes at once: R3, R6
    dv = '0;
    dv[7:0] = 8'h02;
    for (int i = 1; i < 8; i++) dv[i*8 +: 8] = 8'(8'h10 + i);
    push_exp(TW'(12'h208 >> 3), dv, 8'hFF);
    do_write(12'h208, 8'h01, cyc);
    do_write(12'h208, 8'h02, cyc);
    for (int i = 1; i < 8; i++) do_write(AW'(12'h208 + i), 8'(8'h10 + i), cyc);
    @(negedge clk);
    check(mem_req, "R6", "full buffer flush", {63'd0, mem_req}, 64'd1);
    wait_drain();

    // chained region crossing: both occupied, oldest goes first: R7, R9
    push_exp(TW'(12'h300 >> 3), 64'h0000000000003231, 8'h03);
    push_exp(TW'(12'h308 >> 3), 64'h0000000000000033, 8'h01);
    do_write(12'h300, 8'h31, cyc);
    do_write(12'h301, 8'h32, cyc);
    do_write(12'h308, 8'h33, cyc);
    @(negedge clk);
    check(mem_req, "R7", "both occupied flush", {63'd0, mem_req}, 64'd1);
    check(mem_addr == TW'(12'h300 >> 3), "R9", "oldest region first",
          {55'd0, mem_addr}, 64'(12'h300 >> 3));
    wait_drain();

    // stall while both buffers busy: R7
    mem_lat = 15;
    push_exp(TW'(12'h500 >> 3), 64'h51, 8'h01);
    push_exp(TW'(12'h508 >> 3), 64'h52, 8'h01);
    push_exp(TW'(12'h510 >> 3), 64'h53, 8'h01);
    do_write(12'h500, 8'h51, cyc);
    do_write(12'h508, 8'h52, cyc);
    check(cyc == 2, "R2", "second buffer no stall", 64'(cyc), 64'd2);
    do_write(12'h510, 8'h53, cyc);
    check(cyc > 5, "R7", "stall until buffer freed", 64'(cyc), 64'd6);
    wait_drain();

    // write into region in flight, snoop coherence: R8, R10
    mem_lat = 12;
    dv = '0;
    for (int i = 0; i < 8; i++) dv[i*8 +: 8] = 8'(8'h40 + i);
    push_exp(TW'(12'h400 >> 3), dv, 8'hFF);
    push_exp(TW'(12'h400 >> 3), 64'h99, 8'h01);
    for (int i = 0; i < 8; i++) do_write(AW'(12'h400 + i), 8'(8'h40 + i), cyc);
    do_write(12'h400, 8'h99, cyc);
    check(cyc == 2, "R8", "write to draining region no stall", 64'(cyc), 64'd2);
    do_snoop(12'h403, h, sd);
    check(h && sd == 8'h43, "R10", "snoop in-flight byte", {55'd0, h, sd}, {55'd0, 1'b1, 8'h43});
    do_snoop(12'h400, h, sd);
    check(h && sd == 8'h99, "R10", "snoop newer buffer wins", {55'd0, h, sd}, {55'd0, 1'b1, 8'h99});
    do_snoop(12'h7F0, h, sd);
    check(!h, "R10", "snoop miss", {63'd0, h}, 64'd0);
    wait_drain();
    do_snoop(12'h400, h, sd);
    check(!h, "R10", "snoop after drain", {63'd0, h}, 64'd0);
    mem_lat = 2;

    // no write lost, program order kept: R3, R9
    check(expq.size() == 0, "R9", "all expected writes seen", 64'(expq.size()), 64'd0);
    begin
      int bad = 0;
      for (int i = 0; i < (1<<AW); i++)
        if (model[i] !== shadow[i]) bad++;
      check(bad == 0, "R3", "memory image matches writes", 64'(bad), 64'd0);
    end
    check(model[12'h400] == 8'h99, "R9", "last write to byte wins in memory",
          {56'd0, model[12'h400]}, 64'h99);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule